// File: doc/BRIEF.md
# Synchronous SRAM Write-Mask and Read-Output Pipeline

This block is the datapath of a small synchronous static memory. On each rising clock edge an input register captures the address, a write word made of bytes, the per-byte enables, a byte-write strobe, a whole-word write strobe and two chip selects. A captured write is committed to the array on the next edge. The array holds the data itself, so the user supplies no write pulse. Reads come out in one of two ways, chosen by a static mode pin. In flow-through mode the array output goes straight to the data port. In pipelined mode the data passes through an output register on the rising edge first.

The output drive flag follows single-cycle-deselect timing. In pipelined mode a read keeps the port driven for exactly one cycle. A deselect captured at an edge clears the drive flag at the next edge, and a write clears it right after its own capture edge. The output enable and the sleep input act on the port asynchronously. Commands captured while the sleep input is high are dropped. Stored data survives sleep and reset. A high-impedance port is modelled as `rd_valid` low with `rd_data` forced to zero.

Top module: `sspipe_top`

## Requirements
- R1: The device is selected when `sel_a`=1 and `sel_b_n`=0. A selected cycle is a write when `gw_en`=1, or when `bw_en`=1 and at least one `byte_en` bit is 1. Every other selected cycle is a read, including `bw_en`=1 with all `byte_en` bits 0. An unselected cycle is a deselect.
- R2: In a byte write without `gw_en`, only byte i (bits [8i+7:8i]) with `byte_en[i]`=1 changes. The other bytes keep their old contents.
- R3: With `gw_en`=1 every byte of the addressed word is written, whatever `bw_en` and `byte_en` are.
- R4: With `mode_pipe`=0, a read captured at edge k drives `rd_valid`=1 and the stored word on `rd_data` from just after edge k until edge k+1.
- R5: With `mode_pipe`=1, a read captured at edge k drives its word from just after edge k+1 until edge k+2.
- R6: With `mode_pipe`=1, if no read is captured at edge k, then `rd_valid` is 0 after edge k+1. A deselect therefore stops the drive one stage sooner than a second-deselect design would.
- R7: In either mode, `rd_valid` is 0 during the cycle after a write is captured.
- R8: A read captured on the edge right after a write to the same address returns the newly written word.
- R9: While `oe`=0, `rd_valid`=0 with no clock edge needed. Whenever `rd_valid`=0, `rd_data` is all zeros.
- R10: While `sleep`=1, `rd_valid`=0 with no clock edge needed. A command captured at an edge where `sleep`=1 neither writes nor reads.
- R11: Array contents are kept through sleep and through reset.
- R12: After reset, with no command captured, `rd_valid`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| mode_pipe | input | 1 | Static read mode: 0 flow-through, 1 pipelined |
| sel_a | input | 1 | Active-high chip select |
| sel_b_n | input | 1 | Active-low chip select |
| addr | input | AW | Word address |
| wr_data | input | NBYTES*BYTE_W | Write word |
| byte_en | input | NBYTES | Per-byte write enables |
| bw_en | input | 1 | Byte-write strobe |
| gw_en | input | 1 | Whole-word write strobe |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request |
| rd_data | output | NBYTES*BYTE_W | Read word, zero when not driven |
| rd_valid | output | 1 | Output drive flag |

## Verification
If the captured command is wrong, it shows on the same cycle in flow-through mode and one edge later in pipelined mode. A read may appear where a deselect was issued, or the data may come out a cycle early or late. A wrong write mask cannot be seen until that address is read back. It then shows as a byte that changed or stayed put against the reference copy. The drive-flag logic is checked on every cycle against a cycle-exact model. Any skew in the single-cycle-deselect behaviour therefore fails within one cycle of the command that caused it.

// File: rtl/sspipe_pkg.sv
package sspipe_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // Classify one sampled cycle from the select and write strobes.
  function automatic cmd_e decode_cmd(input logic selected, input logic gw,
                                      input logic bw, input logic any_byte);
    if (!selected) return CMD_IDLE;
    if (gw || (bw && any_byte)) return CMD_WRITE;
    return CMD_READ;
  endfunction

endpackage

// File: rtl/sspipe_cmd_stage.sv
module sspipe_cmd_stage
  import sspipe_pkg::*;
#(
  parameter int AW     = 4,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int W     = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              selected,
  input  logic [AW-1:0]     addr,
  input  logic [W-1:0]      wr_data,
  input  logic [NBYTES-1:0] byte_en,
  input  logic              bw_en,
  input  logic              gw_en,
  output cmd_e              cmd_q,
  output logic [AW-1:0]     addr_q,
  output logic [W-1:0]      data_q,
  output logic [NBYTES-1:0] mask_q
);

  cmd_e              cmd_d;
  logic [NBYTES-1:0] mask_d;

  always_comb begin
    cmd_d  = sleep ? CMD_IDLE : decode_cmd(selected, gw_en, bw_en, |byte_en);
    mask_d = gw_en ? {NBYTES{1'b1}} : byte_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr;
      data_q <= wr_data;
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/sspipe_array.sv
module sspipe_array #(
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int W     = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [W-1:0]      wdata,
  input  logic [NBYTES-1:0] wmask,
  output logic [W-1:0]      rdata
);

  // One bank per byte lane; storage has no reset so contents are retained.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[b]) bank[addr] <= wdata[b*BYTE_W +: BYTE_W];
    end

    assign rdata[b*BYTE_W +: BYTE_W] = bank[addr];
  end

endmodule

// File: rtl/sspipe_out_stage.sv
module sspipe_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_pipe,
  input  logic         s1_rd,
  input  logic         s1_wr,
  input  logic [W-1:0] arr_data,
  input  logic         oe,
  input  logic         sleep,
  output logic         pipe_vld,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);

  logic [W-1:0] pipe_data;
  logic         drive_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_vld  <= 1'b0;
      pipe_data <= '0;
    end else begin
      pipe_vld <= s1_rd;
      if (s1_rd) pipe_data <= arr_data;
    end
  end

  always_comb begin
    drive_int = mode_pipe ? (pipe_vld && !s1_wr) : s1_rd;
    rd_valid  = drive_int && oe && !sleep;
    rd_data   = rd_valid ? (mode_pipe ? pipe_data : arr_data) : '0;
  end

endmodule

// File: rtl/sspipe_top.sv
module sspipe_top
  import sspipe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pipe,
  input  logic              sel_a,
  input  logic              sel_b_n,
  input  logic [AW-1:0]     addr,
  input  logic [W-1:0]      wr_data,
  input  logic [NBYTES-1:0] byte_en,
  input  logic              bw_en,
  input  logic              gw_en,
  input  logic              oe,
  input  logic              sleep,
  output logic [W-1:0]      rd_data,
  output logic              rd_valid
);

  cmd_e              s1_cmd;
  logic [AW-1:0]     s1_addr;
  logic [W-1:0]      s1_data;
  logic [NBYTES-1:0] s1_mask;
  logic [W-1:0]      arr_data;
  logic              selected;
  logic              s1_rd;
  logic              s1_wr;
  logic              pipe_vld;

  assign selected = sel_a && !sel_b_n;
  assign s1_rd    = (s1_cmd == CMD_READ);
  assign s1_wr    = (s1_cmd == CMD_WRITE);

  sspipe_cmd_stage #(.AW(AW), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .selected(selected),
    .addr(addr), .wr_data(wr_data), .byte_en(byte_en),
    .bw_en(bw_en), .gw_en(gw_en),
    .cmd_q(s1_cmd), .addr_q(s1_addr), .data_q(s1_data), .mask_q(s1_mask)
  );

  sspipe_array #(.DEPTH(DEPTH), .AW(AW), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk(clk), .we(s1_wr), .addr(s1_addr), .wdata(s1_data),
    .wmask(s1_mask), .rdata(arr_data)
  );

  sspipe_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe),
    .s1_rd(s1_rd), .s1_wr(s1_wr), .arr_data(arr_data),
    .oe(oe), .sleep(sleep), .pipe_vld(pipe_vld),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/sspipe_chk.sv
module sspipe_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_pipe,
  input logic         oe,
  input logic         sleep,
  input logic         s1_rd,
  input logic         s1_wr,
  input logic         rd_valid,
  input logic [W-1:0] rd_data
);

  AST_OE_MUTES: assert property (@(posedge clk) disable iff (!rst_n) !oe |-> !rd_valid); // R9
  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid |-> (rd_data == '0)); // R9
  AST_SLEEP_MUTES: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !rd_valid); // R10
  AST_SLEEP_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n) sleep |=> (!s1_rd && !s1_wr)); // R10
  AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rst_n) s1_wr |-> !rd_valid); // R7
  AST_FLOW_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n) (!mode_pipe && oe && !sleep) |-> (rd_valid == s1_rd)); // R4
  AST_PIPE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n) (mode_pipe && rd_valid) |-> $past(s1_rd)); // R5
  AST_SCD_OFF: assert property (@(posedge clk) disable iff (!rst_n) (mode_pipe && !s1_rd) |=> !rd_valid); // R6

endmodule

bind sspipe_top sspipe_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .oe(oe), .sleep(sleep),
  .s1_rd(s1_rd), .s1_wr(s1_wr), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/sspipe_top_test.sv
module sspipe_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int NB    = 4;
  localparam int BW    = 8;
  localparam int AW    = 4;
  localparam int W     = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_pipe = 1'b0;
  logic          sel_a = 1'b0, sel_b_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [NB-1:0] byte_en = '0;
  logic          bw_en = 1'b0, gw_en = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [W-1:0]  rd_data;
  logic          rd_valid;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  logic [W-1:0]  ref_mem [DEPTH];
  int            m_cmd;       // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_addr;
  logic [W-1:0]  m_data;
  logic [NB-1:0] m_mask;
  logic          m_pv;
  logic [W-1:0]  m_pdata;

  sspipe_top #(.DEPTH(DEPTH), .NBYTES(NB), .BYTE_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .sel_a(sel_a),
    .sel_b_n(sel_b_n), .addr(addr), .wr_data(wr_data), .byte_en(byte_en),
    .bw_en(bw_en), .gw_en(gw_en), .oe(oe), .sleep(sleep),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int kind(input logic sa, input logic sbn, input logic gw,
                              input logic bw, input logic [NB-1:0] be);
    if (!(sa === 1'b1 && sbn === 1'b0)) return 0;
    if (gw || (bw && (be != 0))) return 2;
    return 1;
  endfunction

  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old_w,
      input logic [W-1:0] new_w, input logic [NB-1:0] en);
    logic [W-1:0] r = old_w;
    for (int i = 0; i < NB; i++)
      if (en[i]) r[i*BW +: BW] = new_w[i*BW +: BW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W:0] act,
                     input logic [W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cmd = 0; m_pv = 1'b0; m_addr = '0; m_data = '0; m_mask = '0; m_pdata = '0;
  endtask

  // one clock edge, model update, then compare outputs
  task automatic tick();
    logic ev;
    logic [W-1:0] ed;
    string tag;
    @(posedge clk);
    if (m_cmd == 2) ref_mem[m_addr] = lane_merge(ref_mem[m_addr], m_data, m_mask);
    m_pv = (m_cmd == 1);
    if (m_cmd == 1) m_pdata = ref_mem[m_addr];
    m_cmd  = sleep ? 0 : kind(sel_a, sel_b_n, gw_en, bw_en, byte_en);
    m_addr = addr; m_data = wr_data; m_mask = gw_en ? '1 : byte_en;
    #1;
    if (mode_pipe) ev = m_pv && (m_cmd != 2) && oe && !sleep;
    else           ev = (m_cmd == 1) && oe && !sleep;
    ed = !ev ? '0 : (mode_pipe ? m_pdata : ref_mem[m_addr]);
    if (ev)              tag = mode_pipe ? "R5" : "R4";
    else if (sleep)      tag = "R10";
    else if (!oe)        tag = "R9";
    else if (m_cmd == 2) tag = "R7";
    else if (mode_pipe)  tag = "R6";
    else                 tag = "R1";
    chk({rd_valid, rd_data} === {ev, ed}, tag, {rd_valid, rd_data}, {ev, ed});
  endtask

  task automatic drive(input logic sa, input logic sbn, input logic [AW-1:0] a,
      input logic [W-1:0] d, input logic [NB-1:0] be, input logic bw,
      input logic gw, input logic o, input logic sl);
    @(negedge clk);
    sel_a = sa; sel_b_n = sbn; addr = a; wr_data = d; byte_en = be;
    bw_en = bw; gw_en = gw; oe = o; sleep = sl;
    tick();
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d,
                          input logic [NB-1:0] be, input logic bw, input logic gw);
    drive(1, 0, a, d, be, bw, gw, 1, 0);
  endtask

  task automatic do_idle();
    drive(0, 1, '0, '0, '0, 0, 0, 1, 0);
  endtask

  task automatic read_expect(input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
    drive(1, 0, a, '0, '0, 0, 0, 1, 0);
    if (mode_pipe) do_idle();
    chk(rd_valid === 1'b1 && rd_data === exp, tag, {rd_valid, rd_data}, {1'b1, exp});
  endtask

  task automatic do_reset(input logic pipe);
    @(negedge clk);
    rst_n = 1'b0; mode_pipe = pipe; sel_a = 0; sel_b_n = 1; oe = 1; sleep = 0;
    gw_en = 0; bw_en = 0; byte_en = '0;
    model_reset();
    #(CLK_PERIOD*2);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rd_valid === 1'b0 && rd_data === '0, "R12", {rd_valid, rd_data}, '0);
  endtask

  task automatic random_phase(input int n);
    for (int i = 0; i < n; i++) begin
      drive(($urandom % 100) < 85, ($urandom % 100) < 10, AW'($urandom),
            W'($urandom), NB'($urandom), ($urandom % 100) < 40,
            ($urandom % 100) < 15, ($urandom % 100) < 90, ($urandom % 100) < 5);
    end
  endtask

  task automatic directed();
    // R2 byte masking: lanes 0 and 2 only
    do_write(4'd3, 32'h11223344, 4'b1111, 0, 1);
    do_write(4'd3, 32'hAABBCCDD, 4'b0101, 1, 0);
    do_idle();
    read_expect(4'd3, 32'h11BB33DD, "R2");
    // R3 global write overrides masks
    do_write(4'd5, 32'hCAFEF00D, 4'b0010, 1, 1);
    do_idle();
    read_expect(4'd5, 32'hCAFEF00D, "R3");
    // R1 bw with no byte enables is a read, contents unchanged
    drive(1, 0, 4'd5, 32'h0, 4'b0000, 1, 0, 1, 0);
    if (mode_pipe) do_idle();
    chk(rd_valid === 1'b1 && rd_data === 32'hCAFEF00D, "R1", {rd_valid, rd_data}, {1'b1, 32'hCAFEF00D});
    // R8 read right after write
    do_write(4'd7, 32'h0BADBEEF, 4'b1111, 1, 0);
    read_expect(4'd7, 32'h0BADBEEF, "R8");
    // R9 asynchronous output enable
    drive(1, 0, 4'd7, '0, '0, 0, 0, 1, 0);
    if (mode_pipe) do_idle();
    oe = 1'b0; #1;
    chk(rd_valid === 1'b0 && rd_data === '0, "R9", {rd_valid, rd_data}, '0);
    oe = 1'b1; #1;
    chk(rd_valid === 1'b1 && rd_data === 32'h0BADBEEF, "R9", {rd_valid, rd_data}, {1'b1, 32'h0BADBEEF});
    // R10 asynchronous sleep, writes dropped while asleep; R11 retention
    sleep = 1'b1; #1;
    chk(rd_valid === 1'b0, "R10", {32'h0, rd_valid}, '0);
    drive(1, 0, 4'd7, 32'hFFFFFFFF, 4'b1111, 1, 1, 1, 1);
    drive(1, 0, 4'd7, 32'h12345678, 4'b1111, 1, 0, 1, 1);
    do_idle();
    read_expect(4'd7, 32'h0BADBEEF, "R11");
    // R6 pipelined read then deselect: exactly one cycle of drive
    if (mode_pipe) begin
      drive(1, 0, 4'd3, '0, '0, 0, 0, 1, 0);
      do_idle();
      chk(rd_valid === 1'b1, "R5", {32'h0, rd_valid}, 1);
      do_idle();
      chk(rd_valid === 1'b0, "R6", {32'h0, rd_valid}, 0);
      // R7 write right after read mutes the pending pipelined data
      drive(1, 0, 4'd3, '0, '0, 0, 0, 1, 0);
      do_write(4'd9, 32'h5, 4'b0001, 1, 0);
      chk(rd_valid === 1'b0, "R7", {32'h0, rd_valid}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    do_reset(1'b0);
    for (int a = 0; a < DEPTH; a++) do_write(AW'(a), W'($urandom), NB'($urandom), 1, 1);
    directed();
    random_phase(400);
    do_reset(1'b1);
    read_expect(4'd3, ref_mem[3], "R11");
    directed();
    random_phase(400);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule